// File: doc/BRIEF.md
# Fixed-Point Requantizer with Saturation

This block narrows a wide signed fixed-point word, for example the result of a multiply or an accumulator, into a shorter signed output word. A typical output is a 16-bit word with 15 fractional bits. It drops a fixed number of low-order fractional bits, set by the parameter `SHIFT` at design time. It then fits the remaining integer part into the output width.

Two mode inputs are sampled with each valid input word, so the policy can change from one word to the next. The first selects how the dropped bits are handled: plain truncation, or rounding to nearest by adding half an output LSB. The second selects what happens when the value does not fit: clamping to the output's extreme values, or keeping the low bits in two's-complement fashion. The result is registered with one cycle of latency.

Any out-of-range word that is accepted sets a sticky overflow flag. The flag stays set until a clear input is asserted.

Top module: `fxq_requant`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_data` and `ovf_sticky` are all 0 after that edge.
- R2: `out_valid` at each edge equals `in_valid` sampled at the previous edge (one cycle of latency).
- R3: With `round_en`=0 (truncate), the intermediate value is floor(`in_data` / 2^SHIFT). This is an arithmetic right shift, so negative values move toward minus infinity and the error is below one output LSB.
- R4: With `round_en`=1 (nearest), the intermediate value is floor((`in_data` + 2^(SHIFT-1)) / 2^SHIFT). Exact halves therefore round up, and the error is at most half an output LSB.
- R5: With `sat_en`=1, an intermediate value above the largest output value gives 0x7FFF (the largest positive code). A value below the smallest output value gives 0x8000 (the most negative code). An in-range value passes through unchanged.
- R6: With `sat_en`=0 (wrap), `out_data` is the low OUT_W bits of the intermediate value. For example, an intermediate value of 32800 appears as 0x8020 (-32736).
- R7: The range check is applied after the rounding addition. A value that rounds up past the largest code is treated as an overflow, and a value that rounds back into range is not.
- R8: An accepted word whose intermediate value is out of range sets `ovf_sticky` at the same edge as its output, in either overflow mode. Once set, the flag stays at 1 while `ovf_clear` is low.
- R9: `ovf_clear`=1 at an edge drives `ovf_sticky` to 0, unless an out-of-range word is accepted at that same edge, in which case the flag is 1.
- R10: While `in_valid` is 0, `out_data` holds its value and `ovf_sticky` is not set, whatever `in_data` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | IN_W | Wide signed fixed-point input |
| round_en | input | 1 | 1 = round to nearest, 0 = truncate |
| sat_en | input | 1 | 1 = saturate, 0 = two's-complement wrap |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | OUT_W | Narrow signed fixed-point output |
| ovf_sticky | output | 1 | Sticky overflow indicator |

## Verification
Exact half-LSB values, and values one code below a half, are applied in both rounding modes with positive and negative signs. This separates round-to-nearest from truncation and shows that negative truncation moves toward minus infinity. Values just inside and just outside the output range are applied in both overflow modes. Each mode is tested at both ends of the range, which separates clamping from wrapping and shows that the overflow flag is independent of the overflow mode. Words near the largest code that only overflow once rounded, and negative words that round back into range, check that the range test comes after the rounding addition. Directed sequences cover idle cycles with out-of-range data, the hold of the sticky flag, and a clear that coincides with an overflow.

// File: rtl/fxq_pkg.sv
package fxq_pkg;

    typedef enum logic {
        RND_TRUNC   = 1'b0,
        RND_NEAREST = 1'b1
    } rnd_mode_e;

    typedef enum logic {
        OVF_WRAP = 1'b0,
        OVF_SAT  = 1'b1
    } ovf_mode_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } ovf_flags_t;

    function automatic logic any_ovf(input ovf_flags_t f);
        return f.pos | f.neg;
    endfunction

endpackage

// File: rtl/fxq_round.sv
module fxq_round
    import fxq_pkg::*;
#(
    parameter int IN_W  = 32,
    parameter int SHIFT = 12,
    localparam int KEEP_W = IN_W + 1 - SHIFT
) (
    input  logic [IN_W-1:0]   din,
    input  rnd_mode_e         mode,
    output logic [KEEP_W-1:0] q
);

    logic signed [IN_W:0] ext;

    assign ext = {din[IN_W-1], din};

    generate
        if (SHIFT == 0) begin : g_noshift
            assign q = ext;
        end else begin : g_shift
            logic signed [IN_W:0] bias;
            logic signed [IN_W:0] sum;
            always_comb begin
                bias = '0;
                bias[SHIFT-1] = (mode == RND_NEAREST);
            end
            assign sum = ext + bias;
            assign q   = sum[IN_W:SHIFT];
        end
    endgenerate

endmodule

// File: rtl/fxq_limit.sv
module fxq_limit
    import fxq_pkg::*;
#(
    parameter int KEEP_W = 21,
    parameter int OUT_W  = 16
) (
    input  logic [KEEP_W-1:0] q,
    input  ovf_mode_e         mode,
    output logic [OUT_W-1:0]  y,
    output ovf_flags_t        flags
);

    localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    generate
        if (KEEP_W > OUT_W) begin : g_narrow
            logic [KEEP_W-OUT_W:0] hi;
            logic                  agree;
            assign hi    = q[KEEP_W-1:OUT_W-1];
            assign agree = (&hi) | ~(|hi);
            assign flags.pos = ~agree & ~q[KEEP_W-1];
            assign flags.neg = ~agree &  q[KEEP_W-1];
            always_comb begin
                y = q[OUT_W-1:0];
                if (mode == OVF_SAT) begin
                    if (flags.pos)      y = MAX_CODE;
                    else if (flags.neg) y = MIN_CODE;
                end
            end
        end else if (KEEP_W == OUT_W) begin : g_same
            assign y     = q;
            assign flags = '0;
        end else begin : g_wide
            assign y     = {{(OUT_W-KEEP_W){q[KEEP_W-1]}}, q};
            assign flags = '0;
        end
    endgenerate

endmodule

// File: rtl/fxq_requant.sv
module fxq_requant
    import fxq_pkg::*;
#(
    parameter int IN_W  = 32,
    parameter int OUT_W = 16,
    parameter int SHIFT = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             round_en,
    input  logic             sat_en,
    input  logic             ovf_clear,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             ovf_sticky
);

    localparam int KEEP_W = IN_W + 1 - SHIFT;

    rnd_mode_e         rnd_mode;
    ovf_mode_e         ovf_mode;
    logic [KEEP_W-1:0] shifted;
    logic [OUT_W-1:0]  fitted;
    ovf_flags_t        flags;
    logic              ovf_event;

    assign rnd_mode = rnd_mode_e'(round_en);
    assign ovf_mode = ovf_mode_e'(sat_en);

    fxq_round #(.IN_W(IN_W), .SHIFT(SHIFT)) u_round (
        .din  (in_data),
        .mode (rnd_mode),
        .q    (shifted)
    );

    fxq_limit #(.KEEP_W(KEEP_W), .OUT_W(OUT_W)) u_limit (
        .q     (shifted),
        .mode  (ovf_mode),
        .y     (fitted),
        .flags (flags)
    );

    assign ovf_event = in_valid & any_ovf(flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            ovf_sticky <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            if (in_valid) begin
                out_data <= fitted;
            end
            ovf_sticky <= (ovf_sticky & ~ovf_clear) | ovf_event;
        end
    end

endmodule

// File: rtl/fxq_requant_checks.sv
module fxq_requant_checks #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_data,
    input logic             sat_en,
    input logic             ovf_clear,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             ovf_sticky
);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && !ovf_sticky && out_data == '0));

    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R5: a clamped non-negative input never shows a negative code
    a_r5_sat_pos_sign: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_en && !in_data[IN_W-1]) |=> !out_data[OUT_W-1]);
    a_r5_sat_neg_sign: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_en && in_data[IN_W-1]) |=>
            (out_data[OUT_W-1] || out_data == '0));

    // R8
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (ovf_sticky && !ovf_clear) |=> ovf_sticky);

    // R9
    a_r9_clear_idle: assert property (@(posedge clk) disable iff (rst)
        (ovf_clear && !in_valid) |=> !ovf_sticky);

    // R10
    a_r10_hold_data: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    a_r10_no_set: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !ovf_sticky) |=> !ovf_sticky);

endmodule

bind fxq_requant fxq_requant_checks #(.IN_W(IN_W), .OUT_W(OUT_W)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .sat_en     (sat_en),
    .ovf_clear  (ovf_clear),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .ovf_sticky (ovf_sticky)
);

// File: tb/test_fxq_requant.sv
module test_fxq_requant;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 32;
    localparam int OUT_W = 16;
    localparam int SHIFT = 12;

    typedef struct packed {
        logic [31:0] din;
        logic        rnd;
        logic        sat;
        logic [15:0] dout;
        logic        ovf;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1345, 1'b0, 1'b0, 16'h0001, 1'b0, 8'd3},  // R3 drop fraction
        '{32'h0000_1800, 1'b1, 1'b0, 16'h0002, 1'b0, 8'd4},  // R4 exact half up
        '{32'h0000_17FF, 1'b1, 1'b0, 16'h0001, 1'b0, 8'd4},  // R4 below half
        '{32'h0000_1800, 1'b0, 1'b0, 16'h0001, 1'b0, 8'd3},  // R3 half truncated
        '{32'hFFFF_F800, 1'b0, 1'b0, 16'hFFFF, 1'b0, 8'd3},  // R3 floor of -0.5
        '{32'hFFFF_F800, 1'b1, 1'b0, 16'h0000, 1'b0, 8'd4},  // R4 -0.5 up to 0
        '{32'hFFFF_F7FF, 1'b1, 1'b0, 16'hFFFF, 1'b0, 8'd4},  // R4 below -0.5
        '{32'h07FF_FFFF, 1'b0, 1'b1, 16'h7FFF, 1'b0, 8'd5},  // R5 top in range
        '{32'h07FF_F800, 1'b1, 1'b1, 16'h7FFF, 1'b1, 8'd7},  // R7 rounds past max, clamp
        '{32'h07FF_F800, 1'b1, 1'b0, 16'h8000, 1'b1, 8'd7},  // R7 rounds past max, wrap
        '{32'h07FF_F800, 1'b0, 1'b1, 16'h7FFF, 1'b0, 8'd7},  // R7 truncated stays in range
        '{32'h0802_0000, 1'b0, 1'b0, 16'h8020, 1'b1, 8'd6},  // R6 32800 -> -32736
        '{32'h0802_0000, 1'b0, 1'b1, 16'h7FFF, 1'b1, 8'd5},  // R5 positive clamp
        '{32'hF7FF_F000, 1'b0, 1'b1, 16'h8000, 1'b1, 8'd5},  // R5 negative clamp
        '{32'hF7FF_F000, 1'b0, 1'b0, 16'h7FFF, 1'b1, 8'd6},  // R6 negative wrap
        '{32'hF800_0000, 1'b0, 1'b1, 16'h8000, 1'b0, 8'd5},  // R5 min in range
        '{32'hF7FF_F800, 1'b1, 1'b1, 16'h8000, 1'b0, 8'd7},  // R7 rounds back in range
        '{32'h7FFF_FFFF, 1'b0, 1'b0, 16'hFFFF, 1'b1, 8'd6},  // R6 full-scale wrap
        '{32'h8000_0000, 1'b0, 1'b1, 16'h8000, 1'b1, 8'd5},  // R5 full-scale clamp
        '{32'h8000_0000, 1'b0, 1'b0, 16'h0000, 1'b1, 8'd6}   // R6 full-scale wrap
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [IN_W-1:0]  in_data;
    logic             round_en;
    logic             sat_en;
    logic             ovf_clear;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;
    logic             ovf_sticky;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxq_requant #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) i_fxq_requant (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .round_en   (round_en),
        .sat_en     (sat_en),
        .ovf_clear  (ovf_clear),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .ovf_sticky (ovf_sticky)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] d,
                         input logic r, input logic s, input logic c);
        @(negedge clk);
        in_valid  = v;
        in_data   = d;
        round_en  = r;
        sat_en    = s;
        ovf_clear = c;
    endtask

    task automatic idle();
        drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; in_data = '0; round_en = 1'b0; sat_en = 1'b0; ovf_clear = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "out_valid", 32'(out_valid), 32'd0);
        check("R1", "out_data", 32'(out_data), 32'd0);
        check("R1", "ovf_sticky", 32'(ovf_sticky), 32'd0);
        rst = 1'b0;

        // table walk: clear flag, apply one word, check output and flag
        for (int i = 0; i < NV; i++) begin
            drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
            drive(1'b1, VECS[i].din, VECS[i].rnd, VECS[i].sat, 1'b0);
            idle();
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d data", i),
                  32'(out_data), 32'(VECS[i].dout));
            check("R8", $sformatf("vec%0d flag", i), 32'(ovf_sticky), 32'(VECS[i].ovf));
            check("R2", $sformatf("vec%0d valid", i), 32'(out_valid), 32'd1);
        end

        // R2 valid drops one cycle after in_valid drops
        idle();
        check("R2", "valid low", 32'(out_valid), 32'd0);

        // R10 idle cycles with overflowing data change nothing
        drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
        drive(1'b1, 32'h0000_5000, 1'b0, 1'b1, 1'b0);
        drive(1'b0, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b0);
        idle();
        check("R10", "data held", 32'(out_data), 32'h0005);
        check("R10", "flag not set", 32'(ovf_sticky), 32'd0);

        // R8 flag stays set over in-range words
        drive(1'b1, 32'h0900_0000, 1'b0, 1'b1, 1'b0);
        drive(1'b1, 32'h0000_3000, 1'b0, 1'b1, 1'b0);
        drive(1'b1, 32'h0000_4000, 1'b1, 1'b0, 1'b0);
        idle();
        check("R8", "flag sticky", 32'(ovf_sticky), 32'd1);
        check("R8", "later data", 32'(out_data), 32'h0004);
        repeat (3) idle();
        check("R8", "flag sticky idle", 32'(ovf_sticky), 32'd1);

        // R9 clear coinciding with an overflow leaves flag set
        drive(1'b1, 32'hF000_0000, 1'b0, 1'b0, 1'b1);
        idle();
        check("R9", "clear vs overflow", 32'(ovf_sticky), 32'd1);
        // R9 clear with an in-range word clears
        drive(1'b1, 32'h0000_1000, 1'b0, 1'b0, 1'b1);
        idle();
        check("R9", "clear with in-range", 32'(ovf_sticky), 32'd0);

        // R1 reset mid-run
        drive(1'b1, 32'h0900_0000, 1'b0, 1'b0, 1'b0);
        idle();
        rst = 1'b1;
        @(negedge clk);
        check("R1", "mid reset flag", 32'(ovf_sticky), 32'd0);
        check("R1", "mid reset data", 32'(out_data), 32'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule